// File: doc/BRIEF.md
# Packed Colour Lookup Table Loader

This block holds a 256-entry colour lookup table. Each entry is 24 bits wide and has an 8-bit red, an 8-bit green and an 8-bit blue component. A host loads the table through a narrow port with three parts:

- an index register;
- a 32-bit colour word port;
- a byte-wide control port.

Table entries are three bytes long and the host bus carries four bytes per write. For this reason the host sends entries in groups of four, packed as three words. An entry may therefore start in one word and finish in the next. The block rebuilds each entry from the running byte stream and stores it once all three of its components are present. After each group it moves its own pointer to the next group.

A pixel lookup port reads one entry per cycle with one cycle of latency. A small bank of byte registers, at indices 4 to 7 of the same index space, holds converter settings. These registers wake from reset with fixed start values.

Top module: `clut_packed_loader`

## Requirements
- R1: After reset every table entry reads as zero. `pix_rgb` presents red in bits [23:16], green in bits [15:8] and blue in bits [7:0].
- R2: A write to the index register loads the group pointer with the written index with its two low bits forced to zero, and restarts the byte phase at the first word of a group.
- R3: Within a group, the concatenation of the three words, first word in the most significant position, is the byte stream R0 G0 B0 R1 G1 B1 R2 G2 B2 R3 G3 B3. Each word is consumed most significant byte first. Entry k of the group is stored at pointer + k.
- R4: An entry is stored only when all three of its components have arrived:
  - the first word stores entry 0;
  - the second word stores entry 1;
  - the third word stores entries 2 and 3.
  Entries still waiting for bytes keep their previous contents.
- R5: After the third word of a group, the pointer moves forward by four and the phase returns to the first word. A fourth word then starts the next group.
- R6: The pointer wraps from the group at index 252 to index 0.
- R7: `pix_rgb` shows the entry selected by `pix_idx` at the rising edge one cycle earlier. If a lookup and a write hit the same entry in the same cycle, the lookup returns the value held before that write.
- R8: If an index write and a colour word write occur in the same cycle, the index write takes effect and the colour word is discarded.
- R9: The control bank holds four byte registers at indices 4, 5, 6 and 7, with reset values FF, 00, 70 and 00. `ctl_regs` bits [8k+7:8k] carry the register at index 4+k. A control write stores `ctl_wdata` into the register whose index was the last value written to the index register.
- R10: A control write is ignored when the last written index lies outside 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Index register write strobe |
| addr_wdata | input | 8 | Index value |
| data_we | input | 1 | Colour word write strobe |
| data_wdata | input | 32 | Packed colour word |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| pix_idx | input | 8 | Lookup index |
| pix_rgb | output | 24 | Looked-up entry, one cycle later |
| ctl_regs | output | 32 | Control bank contents |

## Verification
The bench loads a group using an index with nonzero low bits, and looks up the straddling entry between words. This separates correct entry completion from early or shifted storage. Components are chosen with distinct bytes, so a byte-order or carry mistake shows up as a wrong colour.

Follow-on groups test the self-advance and the wrap at index 252. A lookup that collides with a write checks the read-old rule. A simultaneous index and word write checks priority. Control writes are made both inside and outside the bank's index range.

// File: rtl/clut_pkg.sv
package clut_pkg;

   // Position of the next colour word inside a four-entry group
   typedef enum logic [1:0] {
      WP_FIRST = 2'd0,
      WP_MID   = 2'd1,
      WP_LAST  = 2'd2
   } word_ph_e;

   localparam int GROUP_ENTRIES = 4;
   localparam int GROUP_WORDS   = 3;

endpackage

// File: rtl/clut_unpacker.sv
module clut_unpacker
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                addr_we,
   input  logic [IDX_W-1:0]    addr_wdata,
   input  logic                data_we,
   input  logic [4*COMP_W-1:0] data_wdata,
   output logic                wa_en,
   output logic [IDX_W-1:0]    wa_idx,
   output logic [3*COMP_W-1:0] wa_rgb,
   output logic                wb_en,
   output logic [IDX_W-1:0]    wb_idx,
   output logic [3*COMP_W-1:0] wb_rgb,
   output logic [IDX_W-1:0]    grp_base,
   output logic [1:0]          word_ph
);
   localparam int BUS_W   = 4*COMP_W;
   localparam int CARRY_W = 2*COMP_W;

   word_ph_e           ph_q;
   logic [IDX_W-1:0]   base_q;
   logic [CARRY_W-1:0] carry_q;
   logic [COMP_W-1:0]  by [4];
   logic               take;

   // Byte 0 is the most significant byte of the word
   for (genvar k = 0; k < 4; k++) begin : g_bytes
      assign by[k] = data_wdata[BUS_W-1-k*COMP_W -: COMP_W];
   end

   assign take = data_we & ~addr_we;

   always_comb begin
      wa_en  = 1'b0;
      wb_en  = 1'b0;
      wa_idx = base_q;
      wb_idx = base_q + IDX_W'(3);
      wa_rgb = {by[0], by[1], by[2]};
      wb_rgb = {by[1], by[2], by[3]};
      case (ph_q)
         WP_MID: begin
            wa_en  = take;
            wa_idx = base_q + IDX_W'(1);
            wa_rgb = {carry_q[COMP_W-1:0], by[0], by[1]};
         end
         WP_LAST: begin
            wa_en  = take;
            wa_idx = base_q + IDX_W'(2);
            wa_rgb = {carry_q, by[0]};
            wb_en  = take;
         end
         default: begin
            wa_en  = take;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= WP_FIRST;
         base_q  <= '0;
         carry_q <= '0;
      end else if (addr_we) begin
         ph_q    <= WP_FIRST;
         base_q  <= {addr_wdata[IDX_W-1:2], 2'b00};
         carry_q <= '0;
      end else if (data_we) begin
         case (ph_q)
            WP_FIRST: begin
               carry_q <= {{COMP_W{1'b0}}, by[3]};
               ph_q    <= WP_MID;
            end
            WP_MID: begin
               carry_q <= {by[2], by[3]};
               ph_q    <= WP_LAST;
            end
            WP_LAST: begin
               carry_q <= '0;
               ph_q    <= WP_FIRST;
               base_q  <= base_q + IDX_W'(GROUP_ENTRIES);
            end
            default: ph_q <= WP_FIRST;
         endcase
      end
   end

   assign grp_base = base_q;
   assign word_ph  = ph_q;

endmodule

// File: rtl/clut_table.sv
module clut_table #(
   parameter int ENTRIES     = 256,
   parameter int IDX_W       = 8,
   parameter int ENTRY_W     = 24,
   parameter bit RESET_TABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wa_en,
   input  logic [IDX_W-1:0]   wa_idx,
   input  logic [ENTRY_W-1:0] wa_rgb,
   input  logic               wb_en,
   input  logic [IDX_W-1:0]   wb_idx,
   input  logic [ENTRY_W-1:0] wb_rgb,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_rgb
);
   logic [ENTRY_W-1:0] mem [ENTRIES];

   if (RESET_TABLE) begin : g_clr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
         end else begin
            if (wa_en) mem[wa_idx] <= wa_rgb;
            if (wb_en) mem[wb_idx] <= wb_rgb;
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (wa_en) mem[wa_idx] <= wa_rgb;
         if (wb_en) mem[wb_idx] <= wb_rgb;
      end
   end

   // Registered read sees the contents held before this edge's write
   always_ff @(posedge clk) begin
      if (!rst_n) rd_rgb <= '0;
      else        rd_rgb <= mem[rd_idx];
   end

endmodule

// File: rtl/clut_ctl_bank.sv
module clut_ctl_bank #(
   parameter int                     IDX_W    = 8,
   parameter int                     CTL_W    = 8,
   parameter int                     CTL_BASE = 4,
   parameter int                     CTL_NUM  = 4,
   parameter logic [CTL_NUM*CTL_W-1:0] CTL_INIT = 32'h0070_00FF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     addr_we,
   input  logic [IDX_W-1:0]         addr_wdata,
   input  logic                     ctl_we,
   input  logic [CTL_W-1:0]         ctl_wdata,
   output logic [CTL_NUM*CTL_W-1:0] ctl_regs
);
   logic [IDX_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       sel_q <= '0;
      else if (addr_we) sel_q <= addr_wdata;
   end

   for (genvar k = 0; k < CTL_NUM; k++) begin : g_reg
      logic [CTL_W-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= CTL_INIT[k*CTL_W +: CTL_W];
         else if (ctl_we && sel_q == IDX_W'(CTL_BASE + k))
            val_q <= ctl_wdata;
      end
      assign ctl_regs[k*CTL_W +: CTL_W] = val_q;
   end

endmodule

// File: rtl/clut_packed_loader.sv
module clut_packed_loader #(
   parameter int ENTRIES     = 256,
   parameter int COMP_W      = 8,
   parameter bit RESET_TABLE = 1'b1,
   parameter int CTL_BASE    = 4,
   parameter int CTL_NUM     = 4,
   parameter logic [CTL_NUM*COMP_W-1:0] CTL_INIT = 32'h0070_00FF,
   localparam int IDX_W   = $clog2(ENTRIES),
   localparam int ENTRY_W = 3*COMP_W,
   localparam int BUS_W   = 4*COMP_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      addr_we,
   input  logic [IDX_W-1:0]          addr_wdata,
   input  logic                      data_we,
   input  logic [BUS_W-1:0]          data_wdata,
   input  logic                      ctl_we,
   input  logic [COMP_W-1:0]         ctl_wdata,
   input  logic [IDX_W-1:0]          pix_idx,
   output logic [ENTRY_W-1:0]        pix_rgb,
   output logic [CTL_NUM*COMP_W-1:0] ctl_regs
);
   if (ENTRIES < 4 || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("ENTRIES must be a power of two of at least 4");
   end
   if (COMP_W < 1) begin : g_bad_comp
      $error("COMP_W must be positive");
   end
   if (CTL_BASE + CTL_NUM > ENTRIES || CTL_NUM < 1) begin : g_bad_ctl
      $error("control bank must fit inside the index space");
   end

   logic               wa_en, wb_en;
   logic [IDX_W-1:0]   wa_idx, wb_idx;
   logic [ENTRY_W-1:0] wa_rgb, wb_rgb;
   logic [IDX_W-1:0]   grp_base;
   logic [1:0]         word_ph;

   clut_unpacker #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_we   (addr_we),
      .addr_wdata(addr_wdata),
      .data_we   (data_we),
      .data_wdata(data_wdata),
      .wa_en     (wa_en),
      .wa_idx    (wa_idx),
      .wa_rgb    (wa_rgb),
      .wb_en     (wb_en),
      .wb_idx    (wb_idx),
      .wb_rgb    (wb_rgb),
      .grp_base  (grp_base),
      .word_ph   (word_ph)
   );

   clut_table #(
      .ENTRIES    (ENTRIES),
      .IDX_W      (IDX_W),
      .ENTRY_W    (ENTRY_W),
      .RESET_TABLE(RESET_TABLE)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .wa_en (wa_en),
      .wa_idx(wa_idx),
      .wa_rgb(wa_rgb),
      .wb_en (wb_en),
      .wb_idx(wb_idx),
      .wb_rgb(wb_rgb),
      .rd_idx(pix_idx),
      .rd_rgb(pix_rgb)
   );

   clut_ctl_bank #(
      .IDX_W   (IDX_W),
      .CTL_W   (COMP_W),
      .CTL_BASE(CTL_BASE),
      .CTL_NUM (CTL_NUM),
      .CTL_INIT(CTL_INIT)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_we   (addr_we),
      .addr_wdata(addr_wdata),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .ctl_regs  (ctl_regs)
   );

endmodule

// File: rtl/clut_packed_loader_chk.sv
module clut_packed_loader_chk #(
   parameter int IDX_W = 8,
   parameter int CR_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             addr_we,
   input logic [IDX_W-1:0] addr_wdata,
   input logic             data_we,
   input logic             ctl_we,
   input logic [CR_W-1:0]  ctl_regs,
   input logic [IDX_W-1:0] grp_base,
   input logic [1:0]       word_ph
);
   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      addr_we |=> (grp_base == {$past(addr_wdata[IDX_W-1:2]), 2'b00}) && (word_ph == 2'd0)); // R2

   AST_ADDR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_we && data_we) |=> (word_ph == 2'd0)); // R8

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      word_ph != 2'd3); // R4

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !addr_we && word_ph != 2'd2) |=>
         (word_ph == $past(word_ph) + 2'd1) && $stable(grp_base)); // R4

   AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !addr_we && word_ph == 2'd2) |=>
         (grp_base == $past(grp_base) + IDX_W'(4)) && (word_ph == 2'd0)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_we && !addr_we) |=> $stable(grp_base) && $stable(word_ph)); // R2

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(ctl_regs)); // R9

endmodule

bind clut_packed_loader clut_packed_loader_chk #(
   .IDX_W(IDX_W),
   .CR_W (CTL_NUM*COMP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_we   (addr_we),
   .addr_wdata(addr_wdata),
   .data_we   (data_we),
   .ctl_we    (ctl_we),
   .ctl_regs  (ctl_regs),
   .grp_base  (grp_base),
   .word_ph   (word_ph)
);

// File: tb/sim_clut_packed_loader.sv
module sim_clut_packed_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_we = 1'b0;
   logic [7:0]  addr_wdata = '0;
   logic        data_we = 1'b0;
   logic [31:0] data_wdata = '0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;
   logic [31:0] ctl_regs;

   always #5 clk = ~clk;

   clut_packed_loader u0 (
      .clk(clk), .rst_n(rst_n),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .data_we(data_we), .data_wdata(data_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb), .ctl_regs(ctl_regs)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [23:0] model [256];
   logic [23:0] exp_q [$];
   string       tag_q [$];
   logic        look_v = 1'b0;
   logic        chk_v = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: compares lookup results one cycle after the request
   always @(posedge clk) chk_v <= look_v;
   always @(negedge clk) begin
      if (chk_v) begin
         logic [23:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {8'h00, pix_rgb}, {8'h00, e});
      end
   end

   task automatic look(input logic [7:0] idx, input string tag);
      @(negedge clk);
      pix_idx = idx;
      look_v  = 1'b1;
      exp_q.push_back(model[idx]);
      tag_q.push_back(tag);
      @(negedge clk);
      look_v = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk);
      addr_we = 1'b1; addr_wdata = a;
      @(negedge clk);
      addr_we = 1'b0;
   endtask

   task automatic wr_word(input logic [31:0] w);
      @(negedge clk);
      data_we = 1'b1; data_wdata = w;
      @(negedge clk);
      data_we = 1'b0;
   endtask

   task automatic ctl_write(input logic [7:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   // R3: the group's entries concatenated form the big-endian byte stream
   function automatic logic [31:0] word_of(input logic [95:0] grp, input int w);
      return grp[95-32*w -: 32];
   endfunction

   // Loads a whole group; the model follows the completion rule of R4
   task automatic load_group(input logic [7:0] base, input logic [95:0] grp);
      for (int w = 0; w < 3; w++) begin
         wr_word(word_of(grp, w));
         if (w == 0) model[base] = grp[95:72];
         if (w == 1) model[8'(base+1)] = grp[71:48];
         if (w == 2) begin
            model[8'(base+2)] = grp[47:24];
            model[8'(base+3)] = grp[23:0];
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [95:0] g1, g2, g3, g4, g5;
      for (int i = 0; i < 256; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      look(8'h00, "R1 reset entry 0");
      look(8'hFF, "R1 reset entry 255");
      check("R9 reset control bank", ctl_regs, 32'h0070_00FF);

      // R2/R3/R4: unaligned index, entries checked as they complete
      g1 = {24'h112233, 24'h445566, 24'h778899, 24'hAABBCC};
      set_addr(8'h13);
      wr_word(word_of(g1, 0));
      model[8'h10] = g1[95:72];
      look(8'h10, "R4 entry 0 after first word");
      look(8'h11, "R4 straddling entry untouched after first word");
      wr_word(word_of(g1, 1));
      model[8'h11] = g1[71:48];
      look(8'h11, "R4 entry 1 after second word");
      look(8'h12, "R4 entry 2 untouched after second word");
      // R7: lookup colliding with the write that stores entry 3
      @(negedge clk);
      data_we = 1'b1; data_wdata = word_of(g1, 2);
      pix_idx = 8'h13; look_v = 1'b1;
      exp_q.push_back(model[8'h13]);
      tag_q.push_back("R7 same-cycle lookup returns old value");
      @(negedge clk);
      data_we = 1'b0; look_v = 1'b0;
      model[8'h12] = g1[47:24];
      model[8'h13] = g1[23:0];
      look(8'h12, "R3 entry 2 of group");
      look(8'h13, "R3 entry 3 of group");
      look(8'h10, "R1 component order entry 0");

      // R5: next group continues without an index write
      g2 = {24'h0102FE, 24'h80FF01, 24'h5A5AA5, 24'hC3D2E1};
      load_group(8'h14, g2);
      for (int k = 0; k < 4; k++) look(8'(8'h14 + k), "R5 auto advanced group");

      // R8: index write wins over a simultaneous colour word
      @(negedge clk);
      addr_we = 1'b1; addr_wdata = 8'h41;
      data_we = 1'b1; data_wdata = 32'hDEADBEEF;
      @(negedge clk);
      addr_we = 1'b0; data_we = 1'b0;
      g3 = {24'h010203, 24'h040506, 24'h070809, 24'h0A0B0C};
      load_group(8'h40, g3);
      look(8'h18, "R8 discarded word left old pointer untouched");
      look(8'h40, "R8 group after priority write entry 0");
      look(8'h43, "R8 group after priority write entry 3");

      // R6: wrap from the top group to index 0
      g4 = {24'hF0F1F2, 24'hF3F4F5, 24'hF6F7F8, 24'hF9FAFB};
      g5 = {24'h0F1E2D, 24'h3C4B5A, 24'h697887, 24'h96A5B4};
      set_addr(8'hFE);
      load_group(8'hFC, g4);
      load_group(8'h00, g5);
      look(8'hFF, "R6 last entry of top group");
      look(8'h00, "R6 wrapped group entry 0");
      look(8'h03, "R6 wrapped group entry 3");

      // R9/R10: control bank
      set_addr(8'h05);
      ctl_write(8'hAB);
      check("R9 control write index 5", ctl_regs, 32'h0070_ABFF);
      set_addr(8'h07);
      ctl_write(8'h12);
      check("R9 control write index 7", ctl_regs, 32'h1270_ABFF);
      set_addr(8'h09);
      ctl_write(8'h55);
      check("R10 control write outside bank ignored", ctl_regs, 32'h1270_ABFF);
      set_addr(8'h03);
      ctl_write(8'h66);
      check("R10 control write below bank ignored", ctl_regs, 32'h1270_ABFF);

      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule